// File: doc/BRIEF.md
# Vector Multiply-High Element Unit

This block computes one integer product per cycle for a single vector lane and returns either the lower or the upper half of the double-width result. The caller chooses how the two source elements are interpreted: both signed, both unsigned, or the second source signed with the first source unsigned. A lane controller feeds it the two source elements, a 2-bit operation code, the element's mask state and the element currently held in the destination. One element per cycle leaves the block two cycles later.

When the element is inactive, the block passes the old destination element through unchanged. An element is inactive when the instruction is masked and that element's mask bit is clear. A small combinational decoder beside the datapath pulls the masking flag and the three register indices out of a 32-bit instruction word, so the lane controller can read them without decoding the word itself.

Both operands are widened by one bit, with either sign or zero extension as the operation requires. A single signed multiplier of (SEW+1)x(SEW+1) bits then forms a (2*SEW+2)-bit product, and the result is sliced from that product.

Top module: `vmh_elem_unit`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` is 0 and `out_elem` is 0.
- R2: Operation code 0 returns bits [SEW-1:0] of the product of `in_src2` and `in_src1`.
- R3: Operation code 1 returns bits [2*SEW-1:SEW] of the product with both sources taken as two's-complement signed.
- R4: Operation code 2 returns bits [2*SEW-1:SEW] of the product with both sources taken as unsigned.
- R5: Operation code 3 returns bits [2*SEW-1:SEW] of the product with `in_src2` signed and `in_src1` unsigned.
- R6: The decoder outputs are combinational from `insn_word`: the unmasked flag is bit 25, the second-source index is bits 24:20, the first-source index is bits 19:15, and the destination index is bits 11:7.
- R7: An element is active when `in_unmasked` is 1 or `in_mask_bit` is 1. An inactive element returns `in_old_dst` unchanged, whatever the operation code and sources are.
- R8: An element accepted with `in_valid` high in cycle n appears with `out_valid` high in cycle n+2. `out_valid` is low two cycles after a cycle with `in_valid` low. Back-to-back elements are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An element is presented this cycle |
| in_op | input | 2 | Operation code (0 low, 1 high s*s, 2 high u*u, 3 high s*u) |
| in_src2 | input | SEW | Second source element (signed in codes 1 and 3) |
| in_src1 | input | SEW | First source element (signed only in code 1) |
| in_old_dst | input | SEW | Current destination element, returned when inactive |
| in_unmasked | input | 1 | 1 when the instruction ignores the mask |
| in_mask_bit | input | 1 | This element's mask bit |
| insn_word | input | 32 | Instruction word to decode |
| dec_unmasked | output | 1 | Decoded unmasked flag |
| dec_src2_idx | output | 5 | Decoded second-source register index |
| dec_src1_idx | output | 5 | Decoded first-source register index |
| dec_dst_idx | output | 5 | Decoded destination register index |
| out_valid | output | 1 | Result element valid |
| out_elem | output | SEW | Result element |

## Verification
The embedded properties check the following on every cycle: the two-stage valid timing, that inactive elements pass through, and fixed algebraic points of each operation. Multiplying by one must give the source (low half), the sign fill (signed high) or zero (unsigned high). Multiplying by zero must give zero in the mixed form. Only the bench's scenarios can show that general operands produce the right product halves. These scenarios include random operands, the most-negative squared, all-ones squared, and mixed-sign values near the extremes. Only the bench can also show that the decoder picks the right bit fields.

// File: rtl/vmh_pkg.sv
package vmh_pkg;

    typedef enum logic [1:0] {
        OP_MUL_LO    = 2'd0,
        OP_MUL_HI_SS = 2'd1,
        OP_MUL_HI_UU = 2'd2,
        OP_MUL_HI_SU = 2'd3
    } mul_op_e;

    localparam int REG_IDX_W = 5;

    typedef struct packed {
        logic                 unmasked;
        logic [REG_IDX_W-1:0] src2_idx;
        logic [REG_IDX_W-1:0] src1_idx;
        logic [REG_IDX_W-1:0] dst_idx;
    } insn_fields_t;

endpackage

// File: rtl/vmh_insn_decode.sv
module vmh_insn_decode
    import vmh_pkg::*;
#(
    parameter int INSN_W   = 32,
    parameter int UNM_POS  = 25,
    parameter int SRC2_LSB = 20,
    parameter int SRC1_LSB = 15,
    parameter int DST_LSB  = 7
) (
    input  logic [INSN_W-1:0] insn,
    output insn_fields_t      fields
);
    always_comb begin
        fields.unmasked = insn[UNM_POS];
        fields.src2_idx = insn[SRC2_LSB +: REG_IDX_W];
        fields.src1_idx = insn[SRC1_LSB +: REG_IDX_W];
        fields.dst_idx  = insn[DST_LSB  +: REG_IDX_W];
    end
endmodule

// File: rtl/vmh_operand_ext.sv
module vmh_operand_ext #(
    parameter int SEW = 32
) (
    input  logic [SEW-1:0]    raw,
    input  logic              as_signed,
    output logic signed [SEW:0] ext
);
    localparam int MSB = SEW - 1;

    always_comb begin
        ext = $signed({as_signed & raw[MSB], raw});
    end
endmodule

// File: rtl/vmh_mul_pipe.sv
module vmh_mul_pipe
    import vmh_pkg::*;
#(
    parameter int SEW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  mul_op_e             in_op,
    input  logic signed [SEW:0] a_ext,
    input  logic signed [SEW:0] b_ext,
    input  logic [SEW-1:0]      old_dst,
    input  logic                active,
    output logic                out_valid,
    output logic [SEW-1:0]      out_elem
);
    localparam int PW = 2 * SEW + 2;

    logic                s1_valid;
    mul_op_e             s1_op;
    logic signed [SEW:0] s1_a;
    logic signed [SEW:0] s1_b;
    logic [SEW-1:0]      s1_old;
    logic                s1_active;

    logic signed [PW-1:0] a_w;
    logic signed [PW-1:0] b_w;
    logic signed [PW-1:0] prod;
    logic [SEW-1:0]       picked;
    logic [SEW-1:0]       next_elem;

    // Stage 1: capture widened operands and control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_op     <= OP_MUL_LO;
            s1_a      <= '0;
            s1_b      <= '0;
            s1_old    <= '0;
            s1_active <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            s1_op     <= in_op;
            s1_a      <= a_ext;
            s1_b      <= b_ext;
            s1_old    <= old_dst;
            s1_active <= active;
        end
    end

    // Multiply and select half
    always_comb begin
        a_w  = s1_a;
        b_w  = s1_b;
        prod = a_w * b_w;
        unique case (s1_op)
            OP_MUL_LO:    picked = prod[SEW-1:0];
            OP_MUL_HI_SS: picked = prod[2*SEW-1:SEW];
            OP_MUL_HI_UU: picked = prod[2*SEW-1:SEW];
            OP_MUL_HI_SU: picked = prod[2*SEW-1:SEW];
            default:      picked = '0;
        endcase
        next_elem = s1_active ? picked : s1_old;
    end

    // Stage 2: result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_elem  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_elem <= next_elem;
            end
        end
    end

    a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    a_r8_valid_out: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    a_r8_bubble_out: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    a_r7_inactive_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_active) |=> (out_elem == $past(s1_old)));
    a_r2_lo_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_active && s1_op == OP_MUL_LO && s1_b == 1)
        |=> (out_elem == $past(s1_a[SEW-1:0])));
    a_r3_ss_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_active && s1_op == OP_MUL_HI_SS && s1_b == 1)
        |=> (out_elem == {SEW{$past(s1_a[SEW])}}));
    a_r4_uu_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_active && s1_op == OP_MUL_HI_UU && s1_b == 1)
        |=> (out_elem == '0));
    a_r5_su_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_active && s1_op == OP_MUL_HI_SU && s1_b == 0)
        |=> (out_elem == '0));
endmodule

// File: rtl/vmh_elem_unit.sv
module vmh_elem_unit
    import vmh_pkg::*;
#(
    parameter int SEW    = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [SEW-1:0]    in_src2,
    input  logic [SEW-1:0]    in_src1,
    input  logic [SEW-1:0]    in_old_dst,
    input  logic              in_unmasked,
    input  logic              in_mask_bit,
    input  logic [INSN_W-1:0] insn_word,
    output logic              dec_unmasked,
    output logic [4:0]        dec_src2_idx,
    output logic [4:0]        dec_src1_idx,
    output logic [4:0]        dec_dst_idx,
    output logic              out_valid,
    output logic [SEW-1:0]    out_elem
);
    mul_op_e             op;
    logic                src2_signed;
    logic                src1_signed;
    logic signed [SEW:0] src2_ext;
    logic signed [SEW:0] src1_ext;
    logic                elem_active;
    insn_fields_t        fields;

    always_comb begin
        op          = mul_op_e'(in_op);
        src2_signed = (op != OP_MUL_HI_UU);
        src1_signed = (op == OP_MUL_LO) || (op == OP_MUL_HI_SS);
        elem_active = in_unmasked | in_mask_bit;
    end

    vmh_insn_decode #(.INSN_W(INSN_W)) u_dec (
        .insn   (insn_word),
        .fields (fields)
    );

    assign dec_unmasked = fields.unmasked;
    assign dec_src2_idx = fields.src2_idx;
    assign dec_src1_idx = fields.src1_idx;
    assign dec_dst_idx  = fields.dst_idx;

    vmh_operand_ext #(.SEW(SEW)) u_ext2 (
        .raw       (in_src2),
        .as_signed (src2_signed),
        .ext       (src2_ext)
    );

    vmh_operand_ext #(.SEW(SEW)) u_ext1 (
        .raw       (in_src1),
        .as_signed (src1_signed),
        .ext       (src1_ext)
    );

    vmh_mul_pipe #(.SEW(SEW)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (op),
        .a_ext     (src2_ext),
        .b_ext     (src1_ext),
        .old_dst   (in_old_dst),
        .active    (elem_active),
        .out_valid (out_valid),
        .out_elem  (out_elem)
    );
endmodule

// File: tb/vmh_elem_unit_tb.sv
module vmh_elem_unit_tb;
    localparam int SEW = 32;
    localparam int PW  = 2 * SEW + 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [1:0]      in_op;
    logic [SEW-1:0]  in_src2, in_src1, in_old_dst;
    logic            in_unmasked, in_mask_bit;
    logic [31:0]     insn_word;
    logic            dec_unmasked;
    logic [4:0]      dec_src2_idx, dec_src1_idx, dec_dst_idx;
    logic            out_valid;
    logic [SEW-1:0]  out_elem;

    int checks = 0;
    int errors = 0;

    logic           p_v [2];
    logic [SEW-1:0] p_e [2];
    string          p_t [2];

    always #5 clk = ~clk;

    vmh_elem_unit #(.SEW(SEW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src2(in_src2), .in_src1(in_src1), .in_old_dst(in_old_dst),
        .in_unmasked(in_unmasked), .in_mask_bit(in_mask_bit),
        .insn_word(insn_word), .dec_unmasked(dec_unmasked),
        .dec_src2_idx(dec_src2_idx), .dec_src1_idx(dec_src1_idx),
        .dec_dst_idx(dec_dst_idx), .out_valid(out_valid), .out_elem(out_elem)
    );

    function automatic logic [SEW-1:0] model(input logic [1:0] op,
        input logic [SEW-1:0] a, input logic [SEW-1:0] b,
        input logic [SEW-1:0] old, input logic act);
        logic signed [PW-1:0] sa, sb, p;
        logic a_s, b_s;
        if (!act) return old;
        a_s = (op != 2'd2);
        b_s = (op == 2'd0) || (op == 2'd1);
        sa = a_s ? {{(SEW+2){a[SEW-1]}}, a} : {{(SEW+2){1'b0}}, a};
        sb = b_s ? {{(SEW+2){b[SEW-1]}}, b} : {{(SEW+2){1'b0}}, b};
        p  = sa * sb;
        return (op == 2'd0) ? p[SEW-1:0] : p[2*SEW-1:SEW];
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op,
        input logic [SEW-1:0] a, input logic [SEW-1:0] b,
        input logic [SEW-1:0] old, input logic unm, input logic mb,
        input string tag);
        @(negedge clk);
        check("R8 out_valid timing", 64'(out_valid), 64'(p_v[1]));
        if (p_v[1]) check(p_t[1], 64'(out_elem), 64'(p_e[1]));
        p_v[1] = p_v[0]; p_e[1] = p_e[0]; p_t[1] = p_t[0];
        p_v[0] = v;
        p_e[0] = model(op, a, b, old, unm | mb);
        p_t[0] = tag;
        in_valid = v; in_op = op; in_src2 = a; in_src1 = b;
        in_old_dst = old; in_unmasked = unm; in_mask_bit = mb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        p_v[0] = 0; p_v[1] = 0; p_e[0] = '0; p_e[1] = '0; p_t[0] = ""; p_t[1] = "";
        rst_n = 1'b0; in_valid = 0; in_op = 0; in_src2 = 0; in_src1 = 0;
        in_old_dst = 0; in_unmasked = 1; in_mask_bit = 0; insn_word = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset elem", 64'(out_elem), 64'd0);

        // R6 decoder field positions
        insn_word = 32'h0000_0000;
        insn_word[25] = 1'b1; insn_word[24:20] = 5'd19;
        insn_word[19:15] = 5'd6; insn_word[11:7] = 5'd28;
        #1;
        check("R6 unmasked", 64'(dec_unmasked), 64'd1);
        check("R6 src2 idx", 64'(dec_src2_idx), 64'd19);
        check("R6 src1 idx", 64'(dec_src1_idx), 64'd6);
        check("R6 dst idx", 64'(dec_dst_idx), 64'd28);
        insn_word = 32'hFDFF_FFFF ^ 32'h0000_0000;
        insn_word[24:20] = 5'd0; insn_word[19:15] = 5'd31; insn_word[11:7] = 5'd1;
        #1;
        check("R6 unmasked clear", 64'(dec_unmasked), 64'd0);
        check("R6 src2 idx zero", 64'(dec_src2_idx), 64'd0);
        check("R6 src1 idx max", 64'(dec_src1_idx), 64'd31);
        check("R6 dst idx one", 64'(dec_dst_idx), 64'd1);

        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 64'(out_valid), 64'd0);

        // Directed corners
        step(1, 2'd1, 32'h8000_0000, 32'h8000_0000, 32'h0, 1, 0, "R3 min*min high");
        step(1, 2'd0, 32'h8000_0000, 32'h8000_0000, 32'h0, 1, 0, "R2 min*min low");
        step(1, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1, 0, "R4 ones*ones high");
        step(1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1, 0, "R2 ones*ones low");
        step(1, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1, 0, "R3 neg1*neg1 high");
        step(1, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1, 0, "R5 neg1*umax high");
        step(1, 2'd3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1, 0, "R5 smax*umax high");
        step(1, 2'd3, 32'h8000_0000, 32'h8000_0000, 32'h0, 1, 0, "R5 min*2^31 high");
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 1, 0, "R8 bubble");
        step(1, 2'd2, 32'h1234_5678, 32'h9ABC_DEF0, 32'hDEAD_BEEF, 0, 0, "R7 inactive keeps old");
        step(1, 2'd1, 32'h1234_5678, 32'h9ABC_DEF0, 32'hDEAD_BEEF, 0, 1, "R7 mask bit active");
        step(1, 2'd0, 32'h0000_0003, 32'h0000_0005, 32'hCAFE_F00D, 0, 0, "R7 inactive low op");
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 1, 0, "R8 bubble");
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 1, 0, "R8 bubble");

        // Random back-to-back stream
        for (int i = 0; i < 400; i++) begin
            logic [1:0] op_r;
            op_r = 2'($urandom_range(0, 3));
            step(1'($urandom_range(0, 7) != 0), op_r, $urandom(), $urandom(),
                 $urandom(), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
                 (op_r == 2'd0) ? "R2 random low" : (op_r == 2'd1) ? "R3 random ss" :
                 (op_r == 2'd2) ? "R4 random uu" : "R5 random su");
        end

        // Flush
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 1, 0, "R8 flush");
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 1, 0, "R8 flush");
        step(0, 2'd0, 32'h0, 32'h0, 32'h0, 1, 0, "R8 flush");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule